// File: doc/BRIEF.md
# Masked Fixed-Priority Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines (32 by default) into a single request to the CPU. Each line can be blocked by a mask bit. Software never writes the mask directly. One write port sets mask bits and a separate write port clears them, so two agents can each change their own bits without a read-modify-write race. Line 0 is wired to the timer, line 1 to the keyboard and line 2 to the network interface. The other lines are free for other sources.

Software can read back four things: the mask, the raw level of every line, the winning line as a one-hot word, and the winning line as a number. The winner is the lowest-numbered line that is active and not masked. When nothing qualifies, the number reads as all ones, which a handler can test in a single compare. The CPU request output is combinational from the lines and the mask. Read data is registered and appears in the cycle after the read strobe.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until the first unmask write, every mask bit is 1. In that state `cpu_irq` stays low and `bus_rdata` resets to 0.
- R2: A write to byte offset 0x04 sets every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R3: A write to byte offset 0x08 clears every mask bit whose write-data bit is 1. Mask bits whose write-data bit is 0 keep their value.
- R4: A read of offset 0x00 returns the mask, with bit n set meaning line n is blocked. Writes to offsets 0x00, 0x0C, 0x10 and 0x14 change nothing.
- R5: A read of offset 0x0C returns the present level of each line (bit n = line n), whatever the mask.
- R6: A read of offset 0x10 returns a word with only bit n set, where n is the lowest-numbered line that is high and unmasked. It returns 0 when no such line exists.
- R7: A read of offset 0x14 returns that n as an unsigned number. It returns 0xFFFFFFFF when no line is high and unmasked.
- R8: `cpu_irq` is high in exactly the cycles in which at least one line is high and unmasked.
- R9: Read data is captured at the clock edge where `bus_rd_en` is high and is held until the next read. Offsets 0x04, 0x08, 0x18 and 0x1C read as 0. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 5 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | 32 | Level-sensitive interrupt request lines |
| cpu_irq | output | 1 | Combined request to the CPU |

## Verification
Some properties are checked by assertions on every cycle:
- the winner word is one-hot or zero;
- any winner is a line that is both high and unmasked;
- `cpu_irq` agrees with the existence of a winner;
- the sentinel number appears whenever there is no winner;
- the mask moves only on set or clear writes, and each such write has its stated effect.

The following can only be shown by the bench scenarios, which read values back through the register interface:
- that the lowest-numbered line wins over higher ones;
- that the encoded number matches the one-hot bit;
- the register offset decode;
- the read latency;
- the unmapped offsets reading zero.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // Word index of each register, taken from byte address bits [4:2].
  typedef enum logic [2:0] {
    RI_MASK   = 3'd0,
    RI_SET    = 3'd1,
    RI_CLR    = 3'd2,
    RI_RAW    = 3'd3,
    RI_ONEHOT = 3'd4,
    RI_NUM    = 3'd5,
    RI_SPARE6 = 3'd6,
    RI_SPARE7 = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int N_LINES = 32
) (
  input  logic               clk,
  input  logic               rst_core_n,
  input  logic               set_we,
  input  logic               clr_we,
  input  logic [N_LINES-1:0] bits,
  output logic [N_LINES-1:0] mask
);
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] mask_d;
  logic               mask_en;

  always_comb begin
    mask_en = set_we | clr_we;
    mask_d  = mask_q;
    if (set_we)      mask_d = mask_q | bits;
    else if (clr_we) mask_d = mask_q & ~bits;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask = mask_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N_LINES = 32,
  parameter int DATA_W  = 32
) (
  input  logic [N_LINES-1:0] pend,
  output logic [N_LINES-1:0] onehot,
  output logic [DATA_W-1:0]  num_word,
  output logic               any
);
  // seen[g] is high when some line below g is pending.
  logic [N_LINES:0]  seen;
  logic [DATA_W-1:0] num_or;

  assign seen[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_chain
      assign seen[g+1]  = seen[g] | pend[g];
      assign onehot[g]  = pend[g] & ~seen[g];
    end
  endgenerate

  always_comb begin
    num_or = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (onehot[i]) num_or = num_or | DATA_W'(i);
    end
  end

  assign any      = seen[N_LINES];
  assign num_word = any ? num_or : '1;
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_prio_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_core_n,
  input  logic               rd_en,
  input  logic [2:0]         idx,
  input  logic [N_LINES-1:0] mask,
  input  logic [N_LINES-1:0] raw,
  input  logic [N_LINES-1:0] onehot,
  input  logic [DATA_W-1:0]  num_word,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    unique case (reg_idx_e'(idx))
      RI_MASK:   rdata_d = DATA_W'(mask);
      RI_RAW:    rdata_d = DATA_W'(raw);
      RI_ONEHOT: rdata_d = DATA_W'(onehot);
      RI_NUM:    rdata_d = num_word;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rdata_q <= '0;
    else if (rd_en)  rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_LINES-1:0] irq_lines,
  output logic              cpu_irq
);
  localparam int IDX_W = 3;

  logic               rst_core_n;
  logic [IDX_W-1:0]   idx;
  logic               set_we;
  logic               clr_we;
  logic [N_LINES-1:0] mask;
  logic [N_LINES-1:0] pend;
  logic [N_LINES-1:0] win_onehot;
  logic [DATA_W-1:0]  win_num;
  logic               win_any;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  always_comb begin
    idx    = bus_addr[IDX_W+1:2];
    set_we = bus_wr_en && (reg_idx_e'(idx) == RI_SET);
    clr_we = bus_wr_en && (reg_idx_e'(idx) == RI_CLR);
    pend   = irq_lines & ~mask;
  end

  irq_mask_reg #(.N_LINES(N_LINES)) u_mask (
    .clk(clk), .rst_core_n(rst_core_n), .set_we(set_we), .clr_we(clr_we),
    .bits(bus_wdata[N_LINES-1:0]), .mask(mask)
  );

  irq_prio_pick #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_pick (
    .pend(pend), .onehot(win_onehot), .num_word(win_num), .any(win_any)
  );

  irq_read_mux #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_core_n(rst_core_n), .rd_en(bus_rd_en), .idx(idx),
    .mask(mask), .raw(irq_lines), .onehot(win_onehot), .num_word(win_num),
    .rdata(bus_rdata)
  );

  assign cpu_irq = win_any;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_LINES = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input logic               clk,
  input logic               rst_core_n,
  input logic               bus_wr_en,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [N_LINES-1:0] irq_lines,
  input logic [N_LINES-1:0] mask,
  input logic [N_LINES-1:0] win_onehot,
  input logic [DATA_W-1:0]  win_num,
  input logic               cpu_irq
);
  logic wr_set;
  logic wr_clr;
  assign wr_set = bus_wr_en && (bus_addr[4:2] == 3'd1);
  assign wr_clr = bus_wr_en && (bus_addr[4:2] == 3'd2);

  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(win_onehot)); // R6
  AST_WIN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_core_n)
    (win_onehot != '0) |-> ((win_onehot & irq_lines & ~mask) == win_onehot)); // R6
  AST_IRQ_AGREES: assert property (@(posedge clk) disable iff (!rst_core_n)
    cpu_irq == (win_onehot != '0)); // R8
  AST_NUM_SENTINEL: assert property (@(posedge clk) disable iff (!rst_core_n)
    (win_onehot == '0) |-> (win_num == '1)); // R7
  AST_SET_EFFECT: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_set |=> ((mask & $past(bus_wdata[N_LINES-1:0])) == $past(bus_wdata[N_LINES-1:0]))); // R2
  AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_clr |=> ((mask & $past(bus_wdata[N_LINES-1:0])) == '0)); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(wr_set || wr_clr) |=> $stable(mask)); // R4
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .bus_wr_en(bus_wr_en),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_lines(irq_lines),
  .mask(mask), .win_onehot(win_onehot), .win_num(win_num), .cpu_irq(cpu_irq)
);

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_wr_en;
  logic        bus_rd_en;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] irq_lines;
  logic        cpu_irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl_mask;
  logic [31:0] rd;
  logic [31:0] lfsr;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .cpu_irq(cpu_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rdreg(input logic [4:0] a, output logic [31:0] d);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_num(input logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_hot(input logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return 32'h1 << i;
    return 32'h0;
  endfunction

  task automatic check_all(input string tag);
    logic [31:0] p;
    p = irq_lines & ~mdl_mask;
    rdreg(5'h0C, rd); chk({tag, " R5 raw"}, rd, irq_lines);
    rdreg(5'h10, rd); chk({tag, " R6 onehot"}, rd, exp_hot(p));
    rdreg(5'h14, rd); chk({tag, " R7 num"}, rd, exp_num(p));
    rdreg(5'h00, rd); chk({tag, " R4 mask"}, rd, mdl_mask);
    chk({tag, " R8 cpu_irq"}, {31'b0, cpu_irq}, {31'b0, p != 0});
  endtask

  initial begin
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_rd_en = 1'b0;
    bus_addr = '0; bus_wdata = '0; irq_lines = 32'hFFFF_FFFF;
    mdl_mask = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", bus_rdata, 32'h0);
    chk("R1 cpu_irq in reset", {31'b0, cpu_irq}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cpu_irq after reset", {31'b0, cpu_irq}, 32'h0);
    check_all("R1 reset");

    // R4: writes to read-only offsets change nothing
    wr(5'h00, 32'h0); wr(5'h0C, 32'h0); wr(5'h10, 32'h0); wr(5'h14, 32'h0);
    check_all("R4 ro-writes");
    // R9: unmapped and write-only offsets read zero, low address bits ignored
    rdreg(5'h18, rd); chk("R9 off18", rd, 32'h0);
    rdreg(5'h1C, rd); chk("R9 off1C", rd, 32'h0);
    rdreg(5'h04, rd); chk("R9 off04", rd, 32'h0);
    rdreg(5'h08, rd); chk("R9 off08", rd, 32'h0);
    rdreg(5'h03, rd); chk("R9 addr low bits", rd, mdl_mask);

    // R3: unmask everything, then single-line sweep
    wr(5'h08, 32'hFFFF_FFFF); mdl_mask = 32'h0;
    for (int i = 0; i < 32; i++) begin
      irq_lines = 32'h1 << i;
      @(negedge clk);
      check_all("R6 single");
    end
    // lowest-numbered line wins among many
    for (int i = 0; i < 32; i++) begin
      irq_lines = 32'hFFFF_FFFF << i;
      @(negedge clk);
      check_all("R6 band");
    end
    // R2: mask lines one by one with every line high
    irq_lines = 32'hFFFF_FFFF;
    for (int i = 0; i < 32; i++) begin
      wr(5'h04, 32'h1 << i); mdl_mask |= 32'h1 << i;
      check_all("R2 set sweep");
    end
    // R2/R3: zero bits leave mask unchanged
    wr(5'h08, 32'h0000_0005); mdl_mask &= ~32'h0000_0005;
    check_all("R3 partial clear");
    wr(5'h04, 32'h0); check_all("R2 zero set");
    wr(5'h08, 32'h0); check_all("R3 zero clear");

    // R9: read data held without a read strobe
    rdreg(5'h0C, rd);
    irq_lines = 32'h1234_5678;
    @(negedge clk); @(negedge clk);
    chk("R9 hold", bus_rdata, 32'hFFFF_FFFF);

    // mixed patterns
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 48; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      irq_lines = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      if (k[0]) begin wr(5'h04, lfsr & 32'h0F0F_3C3C); mdl_mask |= lfsr & 32'h0F0F_3C3C; end
      else      begin wr(5'h08, lfsr);                 mdl_mask &= ~lfsr; end
      check_all("R8 mixed");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule